// File: doc/BRIEF.md
# Dual Converter Interleaved Start Scheduler

This block paces two analog-to-digital converters that sample the same input, so that together they deliver samples faster than either one could alone. A trigger is accepted only while the block is idle and an interleaved mode is selected. On the trigger cycle the secondary converter is told to start. The primary converter follows a fixed number of clocks later, called the stagger. The next secondary start comes one stagger after that. In fast mode the stagger is 7 clocks and the cycle repeats only while continuous operation is enabled. In slow mode the stagger is 14 clocks, and the secondary converter is restarted on its own every 28 clocks whatever the continuous setting is.

A programmed sample time that does not fit inside the stagger stops the block from arming and sets an error flag. Each converter's done pulse raises a separate end-of-conversion flag one clock later. The same done pulse writes that converter's data word into its half of a packed result word, which is twice the converter data width (32 bits with the default parameters).

Top module: `ilv_trig_top`

## Requirements
- R1: After reset, both start outputs, both end-of-conversion flags, the error flag and the packed result are all zero.
- R2: A trigger is accepted when the block is idle, the mode is fast (`mode_i`=01) or slow (`mode_i`=10), and the sample time is below the stagger. `start_s_o` is high in that same cycle.
- R3: In fast mode, `start_m_o` pulses 7 cycles after the accepted trigger and again 7 cycles after every secondary restart. It is never high in the same cycle as `start_s_o`.
- R4: In slow mode, `start_m_o` pulses 14 cycles after the accepted trigger and again 14 cycles after every secondary restart.
- R5: In slow mode, `start_s_o` pulses again every 28 cycles after the previous secondary start, whatever the value of `cont_i`, for as long as the mode stays slow.
- R6: In fast mode with `cont_i` high, `start_s_o` pulses again 14 cycles after the previous secondary start. With `cont_i` low, one trigger gives exactly one secondary start and one primary start.
- R7: A trigger in an interleaved mode whose sample time is at least the stagger (7 in fast mode, 14 in slow mode) produces no start pulse and sets `err_o` from the next cycle on. `err_o` clears in the cycle after the next accepted trigger.
- R8: A trigger that arrives while a schedule is running, or while the mode is 00 or 11, has no effect on the starts or on `err_o`.
- R9: A secondary restart happens only if, in the cycle just before it, the mode still equals the mode that was armed and, in fast mode, `cont_i` is still high. A primary start whose secondary start has already been issued is always issued.
- R10: `eoc_m_o` and `eoc_s_o` each pulse for exactly one cycle, in the cycle after `done_m_i` or `done_s_i` respectively.
- R11: `done_s_i` loads `res_s_i` into `result_o[31:16]` and `done_m_i` loads `res_m_i` into `result_o[15:0]`, visible in the next cycle. A half whose done pulse is absent keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger request, one cycle |
| mode_i | input | 2 | 00 off, 01 fast, 10 slow, 11 off |
| cont_i | input | 1 | Continuous operation in fast mode |
| smp_i | input | 5 | Programmed sample time in clocks |
| done_m_i | input | 1 | Primary converter done pulse |
| done_s_i | input | 1 | Secondary converter done pulse |
| res_m_i | input | 16 | Primary converter data |
| res_s_i | input | 16 | Secondary converter data |
| start_m_o | output | 1 | Primary converter start pulse |
| start_s_o | output | 1 | Secondary converter start pulse |
| eoc_m_o | output | 1 | Primary end-of-conversion flag |
| eoc_s_o | output | 1 | Secondary end-of-conversion flag |
| result_o | output | 32 | Packed result, secondary in the upper half |
| err_o | output | 1 | Sample time rejected on the last trigger |

## Verification
The bench targets the edges of the sample-time check, at 6 against 7 and 13 against 14. A design with an off-by-one in that comparison would either arm with a sample time that overruns the stagger or refuse a legal one. It clears the mode partway through a run, at random points, to show that a primary start already owed is still issued and that no further secondary restart follows. A design that checks the mode at the wrong moment would cut a pair in half or add one restart too many. It also sends triggers during a running schedule and while the mode is off. A design that re-arms on these would shift every later start or change the error flag.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ILV_OFF  = 2'b00,
    ILV_FAST = 2'b01,
    ILV_SLOW = 2'b10,
    ILV_RSVD = 2'b11
  } ilv_mode_e;

  // stagger between secondary and primary start for the selected pacing
  function automatic int unsigned stagger_of(input logic slow,
                                             input int unsigned fast_gap,
                                             input int unsigned slow_gap);
    return slow ? slow_gap : fast_gap;
  endfunction

  // a sample window must close before the partner converter starts
  function automatic logic smp_fits(input int unsigned smp,
                                    input int unsigned gap);
    return smp < gap;
  endfunction

  // a full interleave cycle spans two staggers
  function automatic int unsigned period_of(input int unsigned gap);
    return 2 * gap;
  endfunction

endpackage

// File: rtl/ilv_sched.sv
module ilv_sched
  import ilv_pkg::*;
#(
  parameter int unsigned STAG_FAST = 7,
  parameter int unsigned STAG_SLOW = 14,
  parameter int unsigned SMP_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [1:0]       mode_i,
  input  logic             cont_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             start_s_o,
  output logic             start_m_o,
  output logic             err_o
);

  localparam int unsigned CNT_W = $clog2(period_of(STAG_SLOW));

  logic             busy_q;
  logic             slow_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  // named internal events
  logic             mode_on;
  logic             slow_in;
  logic             fits;
  logic             accept;
  logic             reject;
  logic [CNT_W-1:0] gap_run;
  logic [CNT_W-1:0] last_run;
  logic             at_wrap;
  logic             keep_going;

  assign mode_on = (mode_i == ILV_FAST) || (mode_i == ILV_SLOW);
  assign slow_in = (mode_i == ILV_SLOW);
  assign fits    = smp_fits(32'(smp_i), stagger_of(slow_in, STAG_FAST, STAG_SLOW));
  assign accept  = trig_i && !busy_q && mode_on && fits;
  assign reject  = trig_i && !busy_q && mode_on && !fits;

  assign gap_run  = CNT_W'(stagger_of(slow_q, STAG_FAST, STAG_SLOW));
  assign last_run = CNT_W'(period_of(stagger_of(slow_q, STAG_FAST, STAG_SLOW)) - 1);
  assign at_wrap  = busy_q && (cnt_q == last_run);
  assign keep_going = (mode_i == (slow_q ? ILV_SLOW : ILV_FAST)) && (slow_q || cont_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slow_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      slow_q <= slow_in;
      cnt_q  <= CNT_W'(1);
    end else if (at_wrap) begin
      busy_q <= keep_going;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (accept) err_q <= 1'b0;
    else if (reject) err_q <= 1'b1;
  end

  assign start_s_o = accept || (busy_q && (cnt_q == '0));
  assign start_m_o = busy_q && (cnt_q == gap_run);
  assign err_o     = err_q;

  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_s_o |-> !start_m_o);

  p_reject_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err_o && !start_s_o && !start_m_o));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !trig_i) |-> (!start_s_o && !start_m_o));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= last_run));

  p_restart_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (at_wrap && !keep_going) |=> !start_s_o || $past(trig_i));

endmodule

// File: rtl/ilv_collect.sv
module ilv_collect #(
  parameter int unsigned RES_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done_m_i,
  input  logic               done_s_i,
  input  logic [RES_W-1:0]   res_m_i,
  input  logic [RES_W-1:0]   res_s_i,
  output logic               eoc_m_o,
  output logic               eoc_s_o,
  output logic [2*RES_W-1:0] result_o
);

  logic [RES_W-1:0] hi_q;
  logic [RES_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_m_o <= 1'b0;
      eoc_s_o <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      eoc_m_o <= done_m_i;
      eoc_s_o <= done_s_i;
      if (done_s_i) hi_q <= res_s_i;
      if (done_m_i) lo_q <= res_m_i;
    end
  end

  assign result_o = {hi_q, lo_q};

  p_eoc_m_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_m_i |=> eoc_m_o);

  p_eoc_s_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_s_i |=> eoc_s_o);

  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_m_i && !done_s_i) |=> $stable(result_o));

endmodule

// File: rtl/ilv_trig_top.sv
module ilv_trig_top #(
  parameter int unsigned STAG_FAST = 7,
  parameter int unsigned STAG_SLOW = 14,
  parameter int unsigned SMP_W     = 5,
  parameter int unsigned RES_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_i,
  input  logic [1:0]         mode_i,
  input  logic               cont_i,
  input  logic [SMP_W-1:0]   smp_i,
  input  logic               done_m_i,
  input  logic               done_s_i,
  input  logic [RES_W-1:0]   res_m_i,
  input  logic [RES_W-1:0]   res_s_i,
  output logic               start_m_o,
  output logic               start_s_o,
  output logic               eoc_m_o,
  output logic               eoc_s_o,
  output logic [2*RES_W-1:0] result_o,
  output logic               err_o
);

  ilv_sched #(
    .STAG_FAST (STAG_FAST),
    .STAG_SLOW (STAG_SLOW),
    .SMP_W     (SMP_W)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_i),
    .mode_i    (mode_i),
    .cont_i    (cont_i),
    .smp_i     (smp_i),
    .start_s_o (start_s_o),
    .start_m_o (start_m_o),
    .err_o     (err_o)
  );

  ilv_collect #(
    .RES_W (RES_W)
  ) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_m_i (done_m_i),
    .done_s_i (done_s_i),
    .res_m_i  (res_m_i),
    .res_s_i  (res_s_i),
    .eoc_m_o  (eoc_m_o),
    .eoc_s_o  (eoc_s_o),
    .result_o (result_o)
  );

endmodule

// File: tb/ilv_trig_top_tb.sv
module ilv_trig_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 70;
  localparam int NEVER      = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        cont_i = 1'b0;
  logic [4:0]  smp_i = '0;
  logic        done_m_i = 1'b0;
  logic        done_s_i = 1'b0;
  logic [15:0] res_m_i = '0;
  logic [15:0] res_s_i = '0;
  logic        start_m_o, start_s_o, eoc_m_o, eoc_s_o, err_o;
  logic [31:0] result_o;

  ilv_trig_top u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .mode_i(mode_i), .cont_i(cont_i),
    .smp_i(smp_i), .done_m_i(done_m_i), .done_s_i(done_s_i), .res_m_i(res_m_i),
    .res_s_i(res_s_i), .start_m_o(start_m_o), .start_s_o(start_s_o),
    .eoc_m_o(eoc_m_o), .eoc_s_o(eoc_s_o), .result_o(result_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  int s_log[32];
  int m_log[32];
  int s_n = 0;
  int m_n = 0;
  logic exp_err = 1'b0;
  logic [31:0] exp_res = '0;

  always @(negedge clk) begin
    if (start_s_o && s_n < 32) begin s_log[s_n] = cyc; s_n++; end
    if (start_m_o && m_n < 32) begin m_log[m_n] = cyc; m_n++; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gap_of(input logic [1:0] m);
    return (m == 2'b10) ? 14 : 7;
  endfunction

  function automatic bit armed_mode(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  // one trigger, with optional mode clear at stop_at and extra trigger at retrig_at
  task automatic run_case(input logic [1:0] m, input logic c, input int smp,
                          input int stop_at, input int retrig_at, input string tag);
    int t0;
    int g;
    bit ok_arm;
    int es[32];
    int em[32];
    int en_s;
    int en_m;
    g = gap_of(m);
    ok_arm = armed_mode(m) && (smp < g);
    @(posedge clk); #1;
    mode_i = m; cont_i = c; smp_i = 5'(smp);
    s_n = 0; m_n = 0;
    @(posedge clk); #1;
    trig_i = 1'b1; t0 = cyc;
    if (armed_mode(m)) exp_err = !ok_arm;
    for (int rel = 1; rel < WIN; rel++) begin
      @(posedge clk); #1;
      if (rel == stop_at) mode_i = 2'b00;
      trig_i = (rel == retrig_at);
      if (rel == 1) chk(err_o == exp_err, {tag, " R7 err"}, int'(err_o), int'(exp_err));
    end
    trig_i = 1'b0; mode_i = 2'b00; cont_i = 1'b0;
    en_s = 0; en_m = 0;
    if (ok_arm) begin
      for (int k = 0; k < 8; k++) begin
        int ts;
        ts = k * 2 * g;
        if (ts >= WIN) break;
        if (k > 0 && !((m == 2'b10 || c) && (ts - 1 < stop_at))) break;
        es[en_s] = ts; en_s++;
        if (ts + g < WIN) begin em[en_m] = ts + g; en_m++; end
      end
    end
    chk(s_n == en_s, {tag, " R2 R5 R6 R9 slave count"}, s_n, en_s);
    chk(m_n == en_m, {tag, " R3 R4 R9 master count"}, m_n, en_m);
    for (int i = 0; i < en_s && i < s_n; i++)
      chk(s_log[i] - t0 == es[i], {tag, " R2 R5 R6 slave time"}, s_log[i] - t0, es[i]);
    for (int i = 0; i < en_m && i < m_n; i++)
      chk(m_log[i] - t0 == em[i], {tag, " R3 R4 master time"}, m_log[i] - t0, em[i]);
    repeat (32) @(posedge clk);
  endtask

  task automatic do_done(input logic dm, input logic ds, input logic [15:0] rm,
                         input logic [15:0] rs);
    @(posedge clk); #1;
    done_m_i = dm; done_s_i = ds; res_m_i = rm; res_s_i = rs;
    if (ds) exp_res[31:16] = rs;
    if (dm) exp_res[15:0] = rm;
    @(posedge clk); #1;
    done_m_i = 1'b0; done_s_i = 1'b0; res_m_i = ~rm; res_s_i = ~rs;
    chk(eoc_m_o == dm, "R10 eoc_m pulse", int'(eoc_m_o), int'(dm));
    chk(eoc_s_o == ds, "R10 eoc_s pulse", int'(eoc_s_o), int'(ds));
    chk(result_o == exp_res, "R11 packed result", int'(result_o), int'(exp_res));
    @(posedge clk); #1;
    chk(!eoc_m_o && !eoc_s_o, "R10 eoc one cycle", int'({eoc_m_o, eoc_s_o}), 0);
    chk(result_o == exp_res, "R11 result held", int'(result_o), int'(exp_res));
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    #1;
    chk(!start_s_o && !start_m_o && !eoc_m_o && !eoc_s_o && !err_o && result_o == 0,
        "R1 reset state", int'(result_o), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!start_s_o && !start_m_o && !err_o && result_o == 0, "R1 after release",
        int'({start_s_o, start_m_o, err_o}), 0);

    // directed pacing cases
    run_case(2'b01, 1'b0, 3,  NEVER, -1, "fast single");
    run_case(2'b01, 1'b1, 6,  NEVER, -1, "fast cont edge6");
    run_case(2'b01, 1'b1, 7,  NEVER, -1, "fast reject7");
    run_case(2'b10, 1'b0, 13, NEVER, -1, "slow edge13");
    run_case(2'b10, 1'b1, 14, NEVER, -1, "slow reject14");
    run_case(2'b10, 1'b0, 2,  20,    -1, "slow stop mid R9");
    run_case(2'b01, 1'b1, 0,  16,     4, "fast stop retrig R8");
    run_case(2'b00, 1'b1, 0,  NEVER, -1, "off R8");
    run_case(2'b11, 1'b0, 0,  NEVER, -1, "rsvd R8");
    run_case(2'b10, 1'b0, 5,  NEVER,  9, "slow retrig R8");

    // constrained random pacing cases
    for (int n = 0; n < 14; n++) begin
      logic [1:0] m;
      logic c;
      int smp;
      int st;
      int rt;
      m   = 2'($urandom_range(0, 3));
      c   = 1'($urandom_range(0, 1));
      smp = $urandom_range(0, 20);
      st  = ($urandom_range(0, 1) == 1) ? $urandom_range(1, 60) : NEVER;
      rt  = ($urandom_range(0, 1) == 1) ? $urandom_range(1, 6) : -1;
      run_case(m, c, smp, st, rt, "random");
    end

    // conversion done handling
    do_done(1'b1, 1'b0, 16'hA5A5, 16'h0000);
    do_done(1'b0, 1'b1, 16'h0000, 16'h3C3C);
    do_done(1'b1, 1'b1, 16'h1234, 16'hFEDC);
    for (int n = 0; n < 8; n++)
      do_done(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              16'($urandom), 16'($urandom));

    finish_run();
  end

endmodule